// File: doc/BRIEF.md
# GPIO Output and Direction Register Bank

This block holds the per-pin control state of a general-purpose I/O bank and drives the pad control lines from it. Each pin has a direction bit that enables its output driver and an output latch bit that supplies the driven level. Software never writes the output latch as a whole word. One register address sets the latch bits that are written with 1, and a second address clears the latch bits that are written with 1. Pins written with 0 keep their latch value in both cases.

The output latch holds its value whatever the direction. An open-drain line therefore needs one clear of its latch bit. After that, direction alone chooses between pulling low (output) and floating (input). The input path is never gated. A separate conditioning stage inverts and filters the pad value before it reaches this block. The read port returns that conditioned value even while the pin is being driven. A per-pin select hands a pin either to GPIO control or to another peripheral. A handed-over pin passes that peripheral's enable and data straight through to the pad.

The write port takes a one-cycle strobe with an address and a data word. The read port has its own strobe and address. Its multiplexer is combinational and its result is captured in a register.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset every direction bit and every output latch bit is 0, and `rd_data` is 0. A GPIO-selected pin therefore comes up with its driver off.
- R2: A write to address 0 loads the whole direction register from `wr_data`. The new value reaches `pad_oe` of the GPIO-selected pins in the cycle after the strobe.
- R3: A write to address 1 sets the latch bit of every pin whose `wr_data` bit is 1. Pins whose data bit is 0 keep their latch value.
- R4: A write to address 2 clears the latch bit of every pin whose `wr_data` bit is 1. Pins whose data bit is 0 keep their latch value.
- R5: The output latch changes only through addresses 1 and 2. Direction writes and writes to address 3 leave it unchanged. A pin whose latch bit is 0 can therefore be switched between driving low and floating by direction writes alone.
- R6: For a pin with `gpio_sel` = 1, `pad_oe` equals its direction bit and `pad_out` equals its latch bit. The driver is never enabled for a GPIO-selected pin whose direction bit is 0.
- R7: For a pin with `gpio_sel` = 0, `pad_oe` and `pad_out` follow `periph_oe` and `periph_out` combinationally, whatever the GPIO state.
- R8: A read of address 3 returns `pin_in_cond` as sampled in the strobe cycle, regardless of the direction bits. The value appears on `rd_data` one cycle after the strobe.
- R9: A read of address 0 returns the direction register. A read of address 1 or address 2 returns the output latch.
- R10: A read and a write in the same cycle return the register value from before the write. A write to address 3 changes no state.
- R11: `rd_data` holds its value in every cycle in which `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 2 | Write address: 0 direction, 1 set, 2 clear, 3 none |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | 2 | Read address: 0 direction, 1/2 latch, 3 conditioned input |
| rd_data | output | NPINS | Registered read result |
| pin_in_cond | input | NPINS | Inverted and filtered pad values from the conditioning stage |
| gpio_sel | input | NPINS | 1 = pin under GPIO control, 0 = pin owned by a peripheral |
| periph_oe | input | NPINS | Peripheral output enables |
| periph_out | input | NPINS | Peripheral output data |
| pad_oe | output | NPINS | Pad driver enables |
| pad_out | output | NPINS | Pad output data |

## Verification
A register read and a write to the same register can land in the same cycle. The bench provokes this by raising both strobes on one clock edge, aimed at the direction register and at the latch. It judges the outcome in two steps. First, the returned word must be the pre-write value the bench model held. Second, a read on the next strobe must show the new value. Around this, the bench sweeps all pin patterns through direction, set, clear, select and input-read. A bench-side model of the latch supplies every expected value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int GPIO_AW = 2;

    typedef enum logic [GPIO_AW-1:0] {
        GA_DIR  = 2'd0,
        GA_SET  = 2'd1,
        GA_CLR  = 2'd2,
        GA_READ = 2'd3
    } gpio_addr_e;

    typedef struct packed {
        logic dir_we;
        logic set_we;
        logic clr_we;
    } gpio_wstb_t;

    function automatic gpio_wstb_t gpio_decode(input logic en, input logic [GPIO_AW-1:0] addr);
        gpio_wstb_t s;
        s.dir_we = en && (addr == GA_DIR);
        s.set_we = en && (addr == GA_SET);
        s.clr_we = en && (addr == GA_CLR);
        return s;
    endfunction

    // next latch bit: clear wins over set
    function automatic logic latch_next(input logic cur, input logic s, input logic c);
        return c ? 1'b0 : (s ? 1'b1 : cur);
    endfunction

endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
    import gpio_bank_pkg::*;
(
    input  logic               wr_en,
    input  logic [GPIO_AW-1:0] wr_addr,
    output gpio_wstb_t         stb
);
    always_comb begin
        stb = gpio_decode(wr_en, wr_addr);
    end
endmodule

// File: rtl/gpio_state_regs.sv
module gpio_state_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  gpio_wstb_t       stb,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
        end else if (stb.dir_we) begin
            dir_q <= wr_data;
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_latch
        logic set_b;
        logic clr_b;
        assign set_b = stb.set_we & wr_data[p];
        assign clr_b = stb.clr_we & wr_data[p];
        always_ff @(posedge clk) begin
            if (rst) begin
                latch_q[p] <= 1'b0;
            end else begin
                latch_q[p] <= latch_next(latch_q[p], set_b, clr_b);
            end
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] gpio_sel,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] latch_q,
    input  logic [NPINS-1:0] periph_oe,
    input  logic [NPINS-1:0] periph_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign pad_oe[p]  = gpio_sel[p] ? dir_q[p]   : periph_oe[p];
        assign pad_out[p] = gpio_sel[p] ? latch_q[p] : periph_out[p];
    end
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [GPIO_AW-1:0] rd_addr,
    input  logic [NPINS-1:0]   dir_q,
    input  logic [NPINS-1:0]   latch_q,
    input  logic [NPINS-1:0]   pin_in_cond,
    output logic [NPINS-1:0]   rd_data
);
    logic [NPINS-1:0] rd_mux;

    always_comb begin
        case (gpio_addr_e'(rd_addr))
            GA_DIR:  rd_mux = dir_q;
            GA_SET,
            GA_CLR:  rd_mux = latch_q;
            default: rd_mux = pin_in_cond;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [GPIO_AW-1:0] wr_addr,
    input  logic [NPINS-1:0]   wr_data,
    input  logic               rd_en,
    input  logic [GPIO_AW-1:0] rd_addr,
    output logic [NPINS-1:0]   rd_data,
    input  logic [NPINS-1:0]   pin_in_cond,
    input  logic [NPINS-1:0]   gpio_sel,
    input  logic [NPINS-1:0]   periph_oe,
    input  logic [NPINS-1:0]   periph_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_out
);
    gpio_wstb_t       stb;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] latch_q;

    gpio_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .stb     (stb)
    );

    gpio_state_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .latch_q (latch_q)
    );

    gpio_pad_mux #(.NPINS(NPINS)) u_pad (
        .gpio_sel   (gpio_sel),
        .dir_q      (dir_q),
        .latch_q    (latch_q),
        .periph_oe  (periph_oe),
        .periph_out (periph_out),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out)
    );

    gpio_rd_port #(.NPINS(NPINS)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .dir_q       (dir_q),
        .latch_q     (latch_q),
        .pin_in_cond (pin_in_cond),
        .rd_data     (rd_data)
    );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [NPINS-1:0] wr_data,
    input logic             rd_en,
    input logic [1:0]       rd_addr,
    input logic [NPINS-1:0] rd_data,
    input logic [NPINS-1:0] pin_in_cond,
    input logic [NPINS-1:0] gpio_sel,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] latch_q
);
    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=> (dir_q == $past(wr_data)));

    // R3
    latch_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1) |=> (latch_q == ($past(latch_q) | $past(wr_data))));

    // R4
    latch_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd2) |=> (latch_q == ($past(latch_q) & ~$past(wr_data))));

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == 2'd1 || wr_addr == 2'd2)) |=> $stable(latch_q));

    // R6
    drv_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & gpio_sel & ~dir_q) == '0) && ((pad_out ^ latch_q) & gpio_sel) == '0);

    // R8
    in_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 2'd3) |=> (rd_data == $past(pin_in_cond)));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .pin_in_cond (pin_in_cond),
    .gpio_sel    (gpio_sel),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .dir_q       (dir_q),
    .latch_q     (latch_q)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [1:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic [N-1:0] pin_in_cond = '0;
    logic [N-1:0] gpio_sel = '1;
    logic [N-1:0] periph_oe = '0;
    logic [N-1:0] periph_out = '0;
    logic [N-1:0] pad_oe;
    logic [N-1:0] pad_out;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] m_dir = '0;
    logic [N-1:0] m_lat = '0;

    always #2.5 clk = ~clk;

    gpio_bank #(.NPINS(N)) i_gpio_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pin_in_cond(pin_in_cond),
        .gpio_sel(gpio_sel), .periph_oe(periph_oe), .periph_out(periph_out),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [N-1:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        v = rd_data;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 rd_data", rd_data, '0);
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        rd(2'd0, v); chk("R1 dir", v, '0);
        rd(2'd1, v); chk("R1 latch", v, '0);

        // R2 / R6 / R9 direction sweep
        for (int i = 0; i < 256; i++) begin
            m_dir = N'(i);
            wr(2'd0, m_dir);
            chk("R2 pad_oe", pad_oe, m_dir);
            if (i % 16 == 5) begin
                rd(2'd0, v); chk("R9 dir read", v, m_dir);
            end
        end

        // R3 / R4 set and clear sweep
        for (int i = 0; i < 256; i++) begin
            logic [N-1:0] s, c;
            s = N'((i * 37 + 11) % 256);
            c = N'((i * 91 + 3) % 256);
            wr(2'd1, s); m_lat = m_lat | s;
            chk("R3 set pad_out", pad_out, m_lat);
            wr(2'd2, c); m_lat = m_lat & ~c;
            chk("R4 clr pad_out", pad_out, m_lat);
            if (i % 32 == 7) begin
                rd(2'd1, v); chk("R9 latch read a1", v, m_lat);
                rd(2'd2, v); chk("R9 latch read a2", v, m_lat);
            end
        end

        // R5 latch retained across direction writes and address 3
        wr(2'd1, 8'hA5); m_lat = m_lat | 8'hA5;
        for (int i = 0; i < 256; i += 7) begin
            m_dir = N'(i);
            wr(2'd0, m_dir);
            chk("R5 latch kept", pad_out, m_lat);
            chk("R6 oe gate", pad_oe, m_dir);
        end
        wr(2'd3, 8'hFF);
        rd(2'd1, v); chk("R10 addr3 latch", v, m_lat);
        rd(2'd0, v); chk("R10 addr3 dir", v, m_dir);

        // R5 open-drain on pin 0
        wr(2'd2, 8'h01); m_lat = m_lat & ~8'h01;
        wr(2'd0, 8'h01); m_dir = 8'h01;
        chk("R5 od drive oe", pad_oe & 8'h01, 8'h01);
        chk("R5 od drive low", pad_out & 8'h01, 8'h00);
        wr(2'd0, 8'h00); m_dir = 8'h00;
        chk("R5 od float", pad_oe & 8'h01, 8'h00);
        chk("R5 od latch low", pad_out & 8'h01, 8'h00);

        // R7 select sweep
        wr(2'd0, 8'h3C); m_dir = 8'h3C;
        for (int s = 0; s < 256; s++) begin
            @(negedge clk);
            gpio_sel = N'(s);
            periph_oe = N'(s) ^ 8'h5A;
            periph_out = ~N'(s * 3);
            #1;
            chk("R7 oe", pad_oe, (gpio_sel & m_dir) | (~gpio_sel & periph_oe));
            chk("R7 out", pad_out, (gpio_sel & m_lat) | (~gpio_sel & periph_out));
        end
        gpio_sel = '1;

        // R8 input read, pins driven
        wr(2'd0, 8'hFF); m_dir = 8'hFF;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pin_in_cond = N'(i);
            rd_en = 1'b1; rd_addr = 2'd3;
            @(negedge clk);
            rd_en = 1'b0;
            pin_in_cond = ~N'(i);
            #1;
            chk("R8 input read", rd_data, N'(i));
        end

        // R11 rd_data held with rd_en low
        v = rd_data;
        pin_in_cond = 8'h0F;
        wr(2'd0, 8'h11); m_dir = 8'h11;
        repeat (4) @(negedge clk);
        #1;
        chk("R11 hold", rd_data, v);

        // R10 same-cycle read and write of direction
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'hC3;
        rd_en = 1'b1; rd_addr = 2'd0;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #1;
        chk("R10 dir old value", rd_data, m_dir);
        m_dir = 8'hC3;
        rd(2'd0, v); chk("R10 dir new value", v, m_dir);

        // R10 same-cycle read and set of latch
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h18;
        rd_en = 1'b1; rd_addr = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        #1;
        chk("R10 latch old value", rd_data, m_lat);
        m_lat = m_lat | 8'h18;
        rd(2'd2, v); chk("R10 latch new value", v, m_lat);

        // R1 reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 re-reset oe", pad_oe, '0);
        chk("R1 re-reset out", pad_out, '0);
        chk("R1 re-reset rd", rd_data, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule